// File: doc/BRIEF.md
# Same-Cycle Ordered Two-Port Register

This block is one storage word with two write ports and two read ports. Inside a single clock cycle the ports behave as if they ran one after another in a fixed order: the first read, then the first write, then the second read, then the second write. Because of this order, the second read sees a value written on the first write port in that same cycle. When both writes land in the same cycle, the second write port's value is the one kept.

The datapath is a chain of two 2:1 selectors in front of one flop. The first selector is steered by the first write enable and the second selector by the second write enable. The first read taps the flop output. The second read taps the point between the two selectors. No port has a guard or a handshake, and all four may be used in every cycle.

A caller that uses only the first read and the first write gets the behaviour of an ordinary register. The extra port pair lets two producers or consumers share the word in one cycle without losing the causal order between them.

Top module: `seq_port_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored word becomes RESET_VAL, and this wins over both write enables. The word is visible on `rd_first` after that edge.
- R2: `rd_first` always equals the word stored at the start of the cycle and is unaffected by that cycle's write inputs.
- R3: When `wr_first_en` is 1, `rd_second` equals `wr_first_data` in the same cycle, through combinational logic only.
- R4: When `wr_first_en` is 0, `rd_second` equals the stored word, whatever the value of `wr_first_data`.
- R5: With `wr_first_en`=1 and `wr_second_en`=0 at an edge (reset low), the stored word becomes `wr_first_data`.
- R6: With `wr_first_en`=0 and `wr_second_en`=1 at an edge (reset low), the stored word becomes `wr_second_data`.
- R7: With both enables at 1 at an edge (reset low), the stored word becomes `wr_second_data`, and `wr_first_data` is discarded.
- R8: With both enables at 0 at an edge (reset low), the stored word keeps its value.

Machine view, kept for naming: there is one state, HOLDING. Each edge takes one of four transitions: RESET_LOAD (R1), TAKE_FIRST (R5), TAKE_SECOND (R6 and R7), or KEEP (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_first_data | input | WIDTH | Data for the earlier write port |
| wr_first_en | input | 1 | Enable for the earlier write port |
| wr_second_data | input | WIDTH | Data for the later write port |
| wr_second_en | input | 1 | Enable for the later write port, which has priority |
| rd_first | output | WIDTH | Stored word as at the start of the cycle |
| rd_second | output | WIDTH | Stored word after the earlier write port in this cycle |

## Verification
A wrong stored word shows up on `rd_first` in the cycle right after the faulty edge. While `wr_first_en` is low, the same wrong word also appears on `rd_second`. A broken bypass or a wrong selector order shows up within the same cycle on `rd_second`, or one edge later as the wrong winner on `rd_first`. Comparing both read ports against a behavioural model on every cycle therefore exposes any fault no more than one clock after it happens.

// File: rtl/spr_pkg.sv
package spr_pkg;
    // number of ordered write stages in the chain
    parameter int unsigned STAGES = 2;
endpackage

// File: rtl/spr_mux_stage.sv
module spr_mux_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] hold_val,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    output logic [WIDTH-1:0] pass_val
);
    always_comb begin
        unique case (wr_en)
            1'b1:    pass_val = wr_data;
            default: pass_val = hold_val;
        endcase
    end
endmodule

// File: rtl/spr_store.sv
module spr_store #(
    parameter int unsigned   WIDTH     = 16,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/seq_port_reg.sv
module seq_port_reg
    import spr_pkg::*;
#(
    parameter int unsigned      WIDTH     = 16,
    parameter logic [WIDTH-1:0] RESET_VAL = 16'hA5C3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_first_data,
    input  logic             wr_first_en,
    input  logic [WIDTH-1:0] wr_second_data,
    input  logic             wr_second_en,
    output logic [WIDTH-1:0] rd_first,
    output logic [WIDTH-1:0] rd_second
);
    logic [WIDTH-1:0] stage_val [STAGES+1];
    logic [WIDTH-1:0] port_data [STAGES];
    logic             port_en   [STAGES];
    logic [WIDTH-1:0] stored;

    assign port_data[0] = wr_first_data;
    assign port_en[0]   = wr_first_en;
    assign port_data[1] = wr_second_data;
    assign port_en[1]   = wr_second_en;
    assign stage_val[0] = stored;

    // ordered chain: later stage overrides earlier stage
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        spr_mux_stage #(.WIDTH(WIDTH)) u_stage (
            .hold_val (stage_val[i]),
            .wr_data  (port_data[i]),
            .wr_en    (port_en[i]),
            .pass_val (stage_val[i+1])
        );
    end

    spr_store #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_store (
        .clk (clk),
        .rst (rst),
        .d   (stage_val[STAGES]),
        .q   (stored)
    );

    assign rd_first  = stored;
    assign rd_second = stage_val[1];

    always_comb begin
        if (!rst && wr_first_en)
            AST_BYPASS_FIRST: assert (rd_second == wr_first_data); // R3
        if (!rst && !wr_first_en)
            AST_SECOND_SEES_STORED: assert (rd_second == rd_first); // R4
    end

    AST_KEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_first_en && !wr_second_en) |=> (rd_first == $past(rd_first))); // R8

    AST_TAKE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (wr_first_en && !wr_second_en) |=> (rd_first == $past(wr_first_data))); // R5

    AST_SECOND_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_second_en |=> (rd_first == $past(wr_second_data))); // R7
endmodule

// File: tb/seq_port_reg_bench.sv
`timescale 1ns/1ps
module seq_port_reg_bench;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] RV = 16'hA5C3;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] wfd, wsd;
    logic wfe, wse;
    logic [W-1:0] rd_first, rd_second;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model_q;
    string next_tag;

    always #2.5 clk = ~clk;

    seq_port_reg #(.WIDTH(W), .RESET_VAL(RV)) u_seq_port_reg (
        .clk(clk), .rst(rst),
        .wr_first_data(wfd), .wr_first_en(wfe),
        .wr_second_data(wsd), .wr_second_en(wse),
        .rd_first(rd_first), .rd_second(rd_second)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check reads, then apply model update at edge
    task automatic cycle(input logic r, input logic fe, input logic [W-1:0] fd,
                         input logic se, input logic [W-1:0] sd);
        logic [W-1:0] exp_second;
        @(negedge clk);
        rst = r; wfe = fe; wfd = fd; wse = se; wsd = sd;
        #1;
        check(next_tag, rd_first, model_q);
        exp_second = fe ? fd : model_q;
        if (!r) check(fe ? "R3" : "R4", rd_second, exp_second);
        @(posedge clk);
        if (r) begin
            model_q = RV; next_tag = "R1";
        end else if (se) begin
            model_q = sd; next_tag = fe ? "R7" : "R6";
        end else if (fe) begin
            model_q = fd; next_tag = "R5";
        end else begin
            next_tag = "R8";
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wfe = 1'b0; wse = 1'b0; wfd = '0; wsd = '0;
        model_q = RV; next_tag = "R1";
        @(posedge clk);
        // reset wins even with both enables high (R1)
        cycle(1'b1, 1'b1, 16'h1111, 1'b1, 16'h2222);
        // idle hold (R8), reads stay put (R2)
        cycle(1'b0, 1'b0, 16'hDEAD, 1'b0, 16'hBEEF);
        cycle(1'b0, 1'b0, 16'h0F0F, 1'b0, 16'hF0F0);
        // first only (R5), bypass to second read (R3)
        cycle(1'b0, 1'b1, 16'h1234, 1'b0, 16'hFFFF);
        // second only (R6)
        cycle(1'b0, 1'b0, 16'h9999, 1'b1, 16'h5678);
        // both: second wins (R7)
        cycle(1'b0, 1'b1, 16'hAAAA, 1'b1, 16'h5555);
        cycle(1'b0, 1'b1, 16'h0000, 1'b1, 16'hFFFF);
        cycle(1'b0, 1'b0, 16'h7777, 1'b0, 16'h8888);
        // mid-run reset back to RV (R1)
        cycle(1'b1, 1'b0, 16'h0001, 1'b1, 16'h0002);
        cycle(1'b0, 1'b0, 16'h0003, 1'b0, 16'h0004);
        for (int i = 0; i < 400; i++) begin
            logic [3:0] pick;
            pick = 4'($urandom);
            cycle(pick == 4'd0, pick[1], W'($urandom), pick[2], W'($urandom));
        end
        cycle(1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule